// File: doc/BRIEF.md
# DDR 4:2:2 Luma/Chroma Input Deserializer

This block sits behind the pins of a double-data-rate video input. On every pixel clock the bus carries two words, one on each clock edge. The block pairs the two words of a pixel, rebuilds one luma sample and one chroma sample from them, and marks whether the chroma is a blue-difference (Cb) or red-difference (Cr) sample. Horizontal sync, vertical sync and data-enable travel alongside and are delayed so that they stay aligned with the rebuilt pixels.

Three static selects set the operating mode. The width select chooses 8, 10 or 12-bit samples. The style select chooses how the sample bits are spread over the two words. The first-edge select chooses which clock edge opens a pixel. The chroma phase is forced to Cb at the start of every data-enable burst, so a 4:2:2 pair always starts where the active region starts.

Top module: `ddr422_deser`

## Requirements
- R1: While `rst` is high and on the first cycles after it, `yOut`, `cOut`, `crOut`, `hsOut`, `vsOut` and `deOut` are all zero.
- R2: `hsOut`, `vsOut` and `deOut` take the values that `hsIn`, `vsIn` and `deIn` had at rising edge k, and change on rising edge k+1. The pixel that belongs to edge k appears on `yOut`/`cOut`/`crOut` on the same edge.
- R3: With `firstRise`=1, the pixel of rising edge k is formed from the word at rising edge k (first) and the word at the following falling edge (second). With `firstRise`=0, it is formed from the word at the falling edge just before rising edge k (first) and the word at rising edge k (second).
- R4: With `styleSel`=1 or 3, `yOut` is the first word and `cOut` is the second word, each taken from bus bits [W-1:0], where W is the sample width.
- R5: With `styleSel`=2, `cOut` is the first word and `yOut` is the second word, each taken from bus bits [W-1:0].
- R6: With `styleSel`=0 and 8-bit width, the first word bits [7:0] are {C[3:0], Y[3:0]} and the second word bits [7:0] are {C[7:4], Y[7:4]}.
- R7: With `styleSel`=0 and 10-bit width, the first word bits [9:0] are {Y[5:4], C[3:0], Y[3:0]} and the second word bits [9:0] are {C[9:4], Y[9:6]}.
- R8: With `styleSel`=0 and 12-bit width, the first word bits [11:0] are {Y[7:4], C[3:0], Y[3:0]} and the second word bits [11:0] are {C[11:4], Y[11:8]}.
- R9: `widthSel` 0, 1, 2 and 3 select 8, 10, 12 and 12 bits. Bus bits at positions W and above are ignored, and the output bits at positions W and above are zero.
- R10: `crOut` is 0 (Cb) on the first pixel of each data-enable burst and toggles on each following pixel while `deOut` stays high.
- R11: On a pixel whose `deOut` is low, `yOut`, `cOut` and `crOut` are zero, and the next burst starts again at Cb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; both edges capture bus words |
| rst | input | 1 | Synchronous active-high reset |
| firstRise | input | 1 | 1: rising edge opens a pixel; 0: falling edge opens it |
| widthSel | input | 2 | Sample width: 0=8, 1=10, 2 or 3=12 bits |
| styleSel | input | 2 | Bit layout: 0 split nibbles, 1 or 3 luma first, 2 chroma first |
| busIn | input | DATA_W | DDR data bus |
| hsIn | input | 1 | Horizontal sync, sampled on the rising edge |
| vsIn | input | 1 | Vertical sync, sampled on the rising edge |
| deIn | input | 1 | Data enable, sampled on the rising edge |
| yOut | output | DATA_W | Rebuilt luma sample, low-aligned |
| cOut | output | DATA_W | Rebuilt chroma sample, low-aligned |
| crOut | output | 1 | 0: chroma is Cb, 1: chroma is Cr |
| hsOut | output | 1 | Delayed horizontal sync |
| vsOut | output | 1 | Delayed vertical sync |
| deOut | output | 1 | Delayed data enable |

## Verification
The bench runs every style at every width with both first-edge settings, plus the two alias codes for style and width. Each run uses random samples with random bits above the sample width. A wrong nibble slice, a swapped edge pairing or a leaked upper bit therefore each show up as a distinct mismatch. The data-enable pattern mixes long odd-length bursts, a one-pixel burst and idle gaps. This separates a phase that restarts at every burst from one that only alternates, and it checks that idle pixels stay zero. Sync pulses that do not line up with data-enable edges expose any difference in delay between the sync path and the data path.

// File: rtl/ddr422_pkg.sv
`timescale 1ns/1ps
package ddr422_pkg;

  typedef enum logic [1:0] {
    WID_8   = 2'd0,
    WID_10  = 2'd1,
    WID_12  = 2'd2,
    WID_12B = 2'd3
  } width_e;

  typedef enum logic [1:0] {
    STY_SPLIT   = 2'd0,
    STY_LUMA1ST = 2'd1,
    STY_CHR1ST  = 2'd2,
    STY_LUMAALT = 2'd3
  } style_e;

  // strobes from control to datapath, valid for the pixel being registered
  typedef struct packed {
    logic active;
    logic isCr;
  } pixCtl_t;

endpackage

// File: rtl/ddr422_ctrl.sv
`timescale 1ns/1ps
module ddr422_ctrl
  import ddr422_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    hsIn,
  input  logic    vsIn,
  input  logic    deIn,
  output pixCtl_t ctl,
  output logic    hsOut,
  output logic    vsOut,
  output logic    deOut
);

  localparam int SYNC_N = 3;

  logic [SYNC_N-1:0] syncQ;
  logic [SYNC_N-1:0] syncOutQ;
  logic              phaseQ;

  // first stage: sample syncs together with the rising-edge word
  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ    <= '0;
      syncOutQ <= '0;
      phaseQ   <= 1'b0;
    end else begin
      syncQ    <= {hsIn, vsIn, deIn};
      syncOutQ <= syncQ;
      // phase parks at Cb while enable is low, toggles per active pixel
      phaseQ   <= syncQ[0] ? ~phaseQ : 1'b0;
    end
  end

  assign ctl.active = syncQ[0];
  assign ctl.isCr   = phaseQ;
  assign {hsOut, vsOut, deOut} = syncOutQ;

  // cycles since reset, used only to bound the latency check window
  logic [1:0] ageQ;
  always_ff @(posedge clk) begin
    if (rst)                ageQ <= 2'd0;
    else if (ageQ != 2'd3)  ageQ <= ageQ + 2'd1;
  end

  // R2
  sync_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (ageQ == 2'd3) |-> ({hsOut, vsOut, deOut} == $past({hsIn, vsIn, deIn}, 2)));

endmodule

// File: rtl/ddr422_path.sv
`timescale 1ns/1ps
module ddr422_path
  import ddr422_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              firstRise,
  input  logic [1:0]        widthSel,
  input  logic [1:0]        styleSel,
  input  logic [DATA_W-1:0] busIn,
  input  pixCtl_t           ctl,
  output logic [DATA_W-1:0] yOut,
  output logic [DATA_W-1:0] cOut,
  output logic              crOut
);

  localparam int NARROW = 8;
  localparam int MID    = 10;
  localparam int WIDE   = 12;
  localparam int PAD_N  = DATA_W - NARROW;
  localparam int PAD_M  = DATA_W - MID;
  localparam logic [DATA_W-1:0] MASK_N = {{PAD_N{1'b0}}, {NARROW{1'b1}}};
  localparam logic [DATA_W-1:0] MASK_M = {{PAD_M{1'b0}}, {MID{1'b1}}};
  localparam logic [DATA_W-1:0] MASK_W = {{(DATA_W-WIDE){1'b0}}, {WIDE{1'b1}}};

  width_e widthMode;
  style_e styleMode;
  assign widthMode = width_e'(widthSel);
  assign styleMode = style_e'(styleSel);

  logic [DATA_W-1:0] riseQ, fallQ, fallHold;

  // capture on both edges; fallHold keeps the falling word one more half cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      riseQ    <= '0;
      fallHold <= '0;
    end else begin
      riseQ    <= busIn;
      fallHold <= fallQ;
    end
  end

  always_ff @(negedge clk) begin
    if (rst) fallQ <= '0;
    else     fallQ <= busIn;
  end

  logic [DATA_W-1:0] firstW, secondW, widthMask, yRaw, cRaw;

  always_comb begin
    firstW  = firstRise ? riseQ : fallHold;
    secondW = firstRise ? fallQ : riseQ;
    yRaw    = '0;
    cRaw    = '0;
    unique case (widthMode)
      WID_8:   widthMask = MASK_N;
      WID_10:  widthMask = MASK_M;
      default: widthMask = MASK_W;
    endcase
    unique case (styleMode)
      STY_SPLIT: begin
        unique case (widthMode)
          WID_8: begin
            yRaw[7:0] = {secondW[3:0], firstW[3:0]};
            cRaw[7:0] = {secondW[7:4], firstW[7:4]};
          end
          WID_10: begin
            yRaw[9:0] = {secondW[3:0], firstW[9:8], firstW[3:0]};
            cRaw[9:0] = {secondW[9:4], firstW[7:4]};
          end
          default: begin
            yRaw[11:0] = {secondW[3:0], firstW[11:8], firstW[3:0]};
            cRaw[11:0] = {secondW[11:4], firstW[7:4]};
          end
        endcase
      end
      STY_CHR1ST: begin
        yRaw = secondW;
        cRaw = firstW;
      end
      default: begin
        yRaw = firstW;
        cRaw = secondW;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      yOut  <= '0;
      cOut  <= '0;
      crOut <= 1'b0;
    end else begin
      yOut  <= ctl.active ? (yRaw & widthMask) : '0;
      cOut  <= ctl.active ? (cRaw & widthMask) : '0;
      crOut <= ctl.active & ctl.isCr;
    end
  end

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(ctl.active) |-> (yOut == '0 && cOut == '0 && !crOut));

  // R9
  narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(widthSel) == WID_8) |-> (yOut[DATA_W-1:NARROW] == '0 && cOut[DATA_W-1:NARROW] == '0));

  // R10
  phase_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ctl.active) && $past(ctl.active, 2)) |-> (crOut != $past(crOut)));

  // R10
  burst_start_cb_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ctl.active) && !$past(ctl.active, 2)) |-> !crOut);

endmodule

// File: rtl/ddr422_deser.sv
`timescale 1ns/1ps
module ddr422_deser
  import ddr422_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              firstRise,
  input  logic [1:0]        widthSel,
  input  logic [1:0]        styleSel,
  input  logic [DATA_W-1:0] busIn,
  input  logic              hsIn,
  input  logic              vsIn,
  input  logic              deIn,
  output logic [DATA_W-1:0] yOut,
  output logic [DATA_W-1:0] cOut,
  output logic              crOut,
  output logic              hsOut,
  output logic              vsOut,
  output logic              deOut
);

  pixCtl_t ctl;

  ddr422_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .hsIn  (hsIn),
    .vsIn  (vsIn),
    .deIn  (deIn),
    .ctl   (ctl),
    .hsOut (hsOut),
    .vsOut (vsOut),
    .deOut (deOut)
  );

  ddr422_path #(.DATA_W(DATA_W)) u_path (
    .clk       (clk),
    .rst       (rst),
    .firstRise (firstRise),
    .widthSel  (widthSel),
    .styleSel  (styleSel),
    .busIn     (busIn),
    .ctl       (ctl),
    .yOut      (yOut),
    .cOut      (cOut),
    .crOut     (crOut)
  );

endmodule

// File: tb/sim_ddr422_deser.sv
`timescale 1ns/1ps
module sim_ddr422_deser;

  localparam int DW = 12;
  localparam int NPIX = 48;

  logic          clk = 1'b0;
  logic          rst;
  logic          firstRise;
  logic [1:0]    widthSel, styleSel;
  logic [DW-1:0] busIn;
  logic          hsIn, vsIn, deIn;
  logic [DW-1:0] yOut, cOut;
  logic          crOut, hsOut, vsOut, deOut;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  ddr422_deser #(.DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .firstRise(firstRise), .widthSel(widthSel),
    .styleSel(styleSel), .busIn(busIn), .hsIn(hsIn), .vsIn(vsIn), .deIn(deIn),
    .yOut(yOut), .cOut(cOut), .crOut(crOut), .hsOut(hsOut), .vsOut(vsOut),
    .deOut(deOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int bitsOf(input int wd);
    return (wd == 0) ? 8 : (wd == 1) ? 10 : 12;
  endfunction

  // returns {first, second}, per the layouts of R4..R8
  function automatic logic [23:0] pack(input int st, input int wd,
                                       input logic [11:0] y, input logic [11:0] c);
    logic [11:0] f, s;
    f = '0; s = '0;
    if (st == 0) begin
      if (wd == 0) begin
        f[7:0] = {c[3:0], y[3:0]};           s[7:0] = {c[7:4], y[7:4]};
      end else if (wd == 1) begin
        f[9:0] = {y[5:4], c[3:0], y[3:0]};   s[9:0] = {c[9:4], y[9:6]};
      end else begin
        f = {y[7:4], c[3:0], y[3:0]};        s = {c[11:4], y[11:8]};
      end
    end else if (st == 2) begin
      f = c; s = y;
    end else begin
      f = y; s = c;
    end
    return {f, s};
  endfunction

  task automatic runPhase(input int st, input int wd, input bit fr, input string tg);
    logic [11:0] pY[NPIX+1], pC[NPIX+1], fW[NPIX+1], sW[NPIX+1];
    logic [11:0] riseW[NPIX+1], fallW[NPIX+1];
    logic [2:0]  pS[NPIX+1];
    int          eCr[NPIX+1];
    logic [11:0] mask;
    int          ph;
    string       dTag;
    mask = 12'((1 << bitsOf(wd)) - 1);
    dTag = {tg, " R3 R9"};
    ph = 0;
    for (int k = 0; k <= NPIX; k++) begin
      logic de;
      logic [23:0] w;
      de = (k >= 2) && (k < NPIX - 1) && (((k % 13) < 9) || (k == 24));
      pS[k] = {((k % 13) == 10), ((k % 29) == 5), de};
      pY[k] = 12'($urandom) & mask;
      pC[k] = 12'($urandom) & mask;
      w = pack(st, wd, pY[k], pC[k]);
      fW[k] = w[23:12] | (12'($urandom) & ~mask);
      sW[k] = w[11:0]  | (12'($urandom) & ~mask);
      if (de) begin eCr[k] = ph; ph ^= 1; end
      else    begin eCr[k] = 0;  ph = 0;  end
    end
    for (int k = 0; k <= NPIX; k++) begin
      if (fr) begin
        riseW[k] = fW[k]; fallW[k] = sW[k];
      end else begin
        riseW[k] = sW[k]; fallW[k] = (k < NPIX) ? fW[k+1] : 12'h0;
      end
    end
    styleSel = 2'(st); widthSel = 2'(wd); firstRise = fr;
    for (int k = 0; k <= NPIX; k++) begin
      busIn = riseW[k];
      {hsIn, vsIn, deIn} = pS[k];
      @(posedge clk); #1;
      busIn = fallW[k];
      @(negedge clk); #1;
      if (k >= 1) begin
        int p;
        p = k - 1;
        chk("R2 sync delay", {hsOut, vsOut, deOut}, pS[p]);
        if (pS[p][0]) begin
          chk({dTag, " luma"},   yOut, pY[p]);
          chk({dTag, " chroma"}, cOut, pC[p]);
          chk("R10 phase", crOut, eCr[p]);
        end else begin
          chk("R11 idle luma",   yOut, 0);
          chk("R11 idle chroma", cOut, 0);
          chk("R11 idle phase",  crOut, 0);
        end
      end
    end
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; firstRise = 1'b1; widthSel = 2'd2; styleSel = 2'd0;
    busIn = '0; hsIn = 1'b0; vsIn = 1'b0; deIn = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk); #1;
    chk("R1 reset outputs", {yOut, cOut, crOut, hsOut, vsOut, deOut}, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk); #1;
    chk("R1 after release", {yOut, cOut, crOut, hsOut, vsOut, deOut}, 0);
    for (int st = 0; st < 3; st++) begin
      for (int wd = 0; wd < 3; wd++) begin
        for (int e = 1; e >= 0; e--) begin
          string tg;
          if (st == 0) tg = (wd == 0) ? "R6" : (wd == 1) ? "R7" : "R8";
          else if (st == 2) tg = "R5";
          else tg = "R4";
          runPhase(st, wd, e[0], tg);
        end
      end
    end
    runPhase(3, 2, 1'b1, "R4 alias");
    runPhase(1, 3, 1'b0, "R4 width alias");
    runPhase(0, 3, 1'b1, "R8 width alias");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule